// File: doc/BRIEF.md
# Repeater Port Isolation Controller

This block decides, for one port of a multi-port repeater, whether that port may drive the repeater core. It watches the port's collision indication together with its transmit and receive activity. A port that shows faulty collision behaviour is isolated. A port can be isolated in two ways: one collision lasts too long, or too many collisions arrive with no clean traffic between them. An isolated port stays isolated until a long packet with no collision passes. Its activity can still be observed while it is isolated. All counting advances only on cycles where the bit-time enable is high.

The reconnection rule can be selected. Under the default rule, a long clean packet in either direction reconnects the port. Once the alternate rule has been selected, only a long clean packet transmitted toward the port counts, and only a reset brings the default rule back. Management disables and then re-enables the port to clear an isolation at once. While the port is disabled, the controller is held in its idle, connected state and its inputs are ignored.

One instance serves one port. The collision indication and the activity signals come from the repeater core. That detection logic is not part of this block.

Top module: `rpt_part_ctrl`

## Requirements
- R1: If the collision indication is high on 1024 (COL_LIMIT) consecutive bit-time samples, part_o rises at the clock edge of the 1024th sample. A collision that ends after 1023 samples does not isolate the port.
- R2: A collision start is a bit-time sample with col_i high where the previous sample had it low. The 32nd (CONSEC_LIMIT) collision start that occurs while the port is connected raises part_o at that sample's clock edge. The 31st does not.
- R3: By default, an isolated port is reconnected (part_o falls) at the edge of the 513th consecutive bit-time sample with tx_act_i or rx_act_i high and col_i low. After 512 such samples the port is still isolated.
- R4: After alt_sel_i has been high on any clock, receive activity alone never reconnects. Only 513 consecutive samples with tx_act_i high and col_i low reconnect the port.
- R5: The default rule applies after reset. Once the alternate rule is selected it stays in force, including across port disable and re-enable, until rst_ni is asserted.
- R6: While port_en_i is low, part_o is 0 from the next clock edge on, and col_i, tx_act_i and rx_act_i have no effect. After re-enable, all counts start from zero.
- R7: While the port is connected, a packet that reaches 513 bit-time samples with no collision (tx_act_i or rx_act_i high) clears the collision-start count. A packet of 512 samples does not clear it.
- R8: A collision during a reconnection attempt returns the port to isolated. The length count restarts, and the rest of that packet cannot reconnect. Only a new packet, after activity has dropped, can do so.
- R9: On clocks where bit_en_i is low and the port is enabled, part_o does not change and no count advances.
- R10: After reset, part_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | Bit-time enable; one sample per high cycle |
| port_en_i | input | 1 | Port enable; low forces idle, connected |
| col_i | input | 1 | Collision indication for this port |
| tx_act_i | input | 1 | Repeater is transmitting to this port |
| rx_act_i | input | 1 | Port is receiving a packet |
| alt_sel_i | input | 1 | Selects transmit-only reconnection (sticky until reset) |
| part_o | output | 1 | Port is isolated from the repeater core |

## Verification
part_o comes straight from the state register. The response to the Nth qualifying bit-time sample therefore appears at the same clock edge that takes in that sample, with no further pipeline delay. The effect of port disable is due one edge after port_en_i falls. The bench drives every input on a falling edge and, after advancing exactly N rising edges, samples part_o on the next falling edge. It checks both sides of each threshold: 1023 and 1024 collision samples, 31 and 32 collision starts, 512 and 513 clean packet samples. With a strobed enable, it counts only the enabled cycles.

// File: rtl/rpt_part_pkg.sv
`timescale 1ns/1ps
package rpt_part_pkg;
  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_COL_WATCH   = 2'd1,
    ST_PART        = 2'd2,
    ST_RECON_WATCH = 2'd3
  } part_state_e;
endpackage

// File: rtl/rpt_sat_cnt.sv
`timescale 1ns/1ps
module rpt_sat_cnt #(
  parameter int unsigned MAX = 1024,
  localparam int unsigned W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MaxV = W'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && cnt_o != MaxV)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rpt_pkt_track.sv
`timescale 1ns/1ps
module rpt_pkt_track #(
  parameter int unsigned RECON_LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic port_en_i,
  input  logic bit_en_i,
  input  logic act_i,
  input  logic col_i,
  output logic clean_o,
  output logic long_o
);
  localparam int unsigned LenW = $clog2(RECON_LEN + 1);
  localparam logic [LenW-1:0] LenV = LenW'(RECON_LEN);

  logic            dirty_q;
  logic [LenW-1:0] len_q;

  // dirty: packet saw a collision; cleared when activity drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dirty_q <= 1'b0;
    else if (!port_en_i)  dirty_q <= 1'b0;
    else if (bit_en_i) begin
      if (!act_i)         dirty_q <= 1'b0;
      else if (col_i)     dirty_q <= 1'b1;
    end
  end

  assign clean_o = bit_en_i & act_i & ~col_i & ~dirty_q;

  rpt_sat_cnt #(.MAX(RECON_LEN)) u_len (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~port_en_i | (bit_en_i & (~act_i | col_i))),
    .inc_i (clean_o),
    .cnt_o (len_q)
  );

  // true on sample RECON_LEN+1 of a clean packet and after
  assign long_o = clean_o & (len_q == LenV);
endmodule

// File: rtl/rpt_part_fsm.sv
`timescale 1ns/1ps
module rpt_part_fsm
  import rpt_part_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        port_en_i,
  input  logic        bit_en_i,
  input  logic        col_i,
  input  logic        trip_i,
  input  logic        clean_i,
  input  logic        long_i,
  output part_state_e state_o
);
  part_state_e state_d;

  always_comb begin
    state_d = state_o;
    if (bit_en_i) begin
      unique case (state_o)
        ST_IDLE: begin
          if (trip_i)     state_d = ST_PART;
          else if (col_i) state_d = ST_COL_WATCH;
        end
        ST_COL_WATCH: begin
          if (trip_i)      state_d = ST_PART;
          else if (!col_i) state_d = ST_IDLE;
        end
        ST_PART: begin
          if (clean_i) state_d = ST_RECON_WATCH;
        end
        ST_RECON_WATCH: begin
          if (long_i)        state_d = ST_IDLE;
          else if (!clean_i) state_d = ST_PART;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_o <= ST_IDLE;
    else if (!port_en_i) state_o <= ST_IDLE;
    else                 state_o <= state_d;
  end
endmodule

// File: rtl/rpt_part_ctrl.sv
`timescale 1ns/1ps
module rpt_part_ctrl
  import rpt_part_pkg::*;
#(
  parameter int unsigned COL_LIMIT    = 1024,
  parameter int unsigned CONSEC_LIMIT = 32,
  parameter int unsigned RECON_LEN    = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic port_en_i,
  input  logic col_i,
  input  logic tx_act_i,
  input  logic rx_act_i,
  input  logic alt_sel_i,
  output logic part_o
);
  localparam int unsigned DurW = $clog2(COL_LIMIT + 1);
  localparam int unsigned SeqW = $clog2(CONSEC_LIMIT + 1);
  localparam logic [DurW-1:0] DurTrip = DurW'(COL_LIMIT - 1);
  localparam logic [SeqW-1:0] SeqTrip = SeqW'(CONSEC_LIMIT - 1);

  part_state_e     state_q;
  logic            alt_q;
  logic            col_seen_q;
  logic [DurW-1:0] dur_q;
  logic [SeqW-1:0] seq_q;
  logic            connected, col_start, trip, pkt_act, clean, long_clean;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        alt_q <= 1'b0;
    else if (alt_sel_i) alt_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         col_seen_q <= 1'b0;
    else if (!port_en_i) col_seen_q <= 1'b0;
    else if (bit_en_i)   col_seen_q <= col_i;
  end

  assign connected = (state_q == ST_IDLE) || (state_q == ST_COL_WATCH);
  assign col_start = col_i & ~col_seen_q;

  rpt_sat_cnt #(.MAX(COL_LIMIT)) u_dur (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~port_en_i | (bit_en_i & (~col_i | ~connected))),
    .inc_i (bit_en_i & col_i & connected),
    .cnt_o (dur_q)
  );

  rpt_sat_cnt #(.MAX(CONSEC_LIMIT)) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~port_en_i | (bit_en_i & (~connected | long_clean))),
    .inc_i (bit_en_i & col_start & connected),
    .cnt_o (seq_q)
  );

  assign trip = bit_en_i & col_i &
                ((dur_q == DurTrip) | (col_start & (seq_q == SeqTrip)));

  // isolated ports qualify by the selected rule; connected ones by any traffic
  assign pkt_act = (connected || !alt_q) ? (tx_act_i | rx_act_i) : tx_act_i;

  rpt_pkt_track #(.RECON_LEN(RECON_LEN)) u_pkt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .port_en_i(port_en_i),
    .bit_en_i (bit_en_i),
    .act_i    (pkt_act),
    .col_i    (col_i),
    .clean_o  (clean),
    .long_o   (long_clean)
  );

  rpt_part_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .port_en_i(port_en_i),
    .bit_en_i (bit_en_i),
    .col_i    (col_i),
    .trip_i   (trip),
    .clean_i  (clean),
    .long_i   (long_clean),
    .state_o  (state_q)
  );

  assign part_o = (state_q == ST_PART) || (state_q == ST_RECON_WATCH);
endmodule

// File: rtl/rpt_part_chk.sv
`timescale 1ns/1ps
module rpt_part_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic port_en_i,
  input logic col_i,
  input logic tx_act_i,
  input logic rx_act_i,
  input logic alt_q_i,
  input logic part_o
);
  AST_ISOLATE_NEEDS_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(part_o) |-> $past(col_i && bit_en_i && port_en_i)); // R1

  AST_ISOLATE_ON_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(part_o) |-> $past(col_i)); // R2

  AST_RECON_NEEDS_TRAFFIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(part_o) && $past(port_en_i)) |->
      $past(bit_en_i && !col_i && (tx_act_i || rx_act_i))); // R3

  AST_ALT_TX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(part_o) && $past(port_en_i) && $past(alt_q_i)) |-> $past(tx_act_i)); // R4

  AST_ALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_q_i |=> alt_q_i); // R5

  AST_DISABLE_CONNECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> !part_o); // R6

  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_en_i && !bit_en_i) |=> $stable(part_o)); // R9
endmodule

bind rpt_part_ctrl rpt_part_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_en_i (bit_en_i),
  .port_en_i(port_en_i),
  .col_i    (col_i),
  .tx_act_i (tx_act_i),
  .rx_act_i (rx_act_i),
  .alt_q_i  (alt_q),
  .part_o   (part_o)
);

// File: tb/rpt_part_ctrl_tb.sv
`timescale 1ns/1ps
module rpt_part_ctrl_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en_i = 1'b1;
  logic port_en_i = 1'b1;
  logic col_i = 1'b0;
  logic tx_act_i = 1'b0;
  logic rx_act_i = 1'b0;
  logic alt_sel_i = 1'b0;
  logic part_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  rpt_part_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .port_en_i(port_en_i),
    .col_i(col_i), .tx_act_i(tx_act_i), .rx_act_i(rx_act_i),
    .alt_sel_i(alt_sel_i), .part_o(part_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input logic exp, input string req);
    n_vec++;
    if (part_o !== exp) begin
      n_bad++;
      $display("FAIL %s: part_o=%0b expected %0b at %0t", req, part_o, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; bit_en_i = 1'b1; port_en_i = 1'b1;
    col_i = 1'b0; tx_act_i = 1'b0; rx_act_i = 1'b0; alt_sel_i = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
  endtask

  task automatic col_pulse();
    col_i = 1'b1; tick(1);
    col_i = 1'b0; tick(1);
  endtask

  task automatic isolate();
    for (int i = 0; i < 32; i++) col_pulse();
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R10 reset state");
  endtask

  task automatic t_long_col();
    do_reset();
    col_i = 1'b1; tick(1023);
    check(1'b0, "R1 1023 samples");
    col_i = 1'b0; tick(1);
    check(1'b0, "R1 collision ended short");
    col_i = 1'b1; tick(1023);
    check(1'b0, "R1 before limit");
    tick(1);
    check(1'b1, "R1 1024 samples");
    col_i = 1'b0; tick(1);
  endtask

  task automatic t_consec();
    do_reset();
    for (int i = 0; i < 31; i++) col_pulse();
    check(1'b0, "R2 31 starts");
    col_pulse();
    check(1'b1, "R2 32 starts");
  endtask

  task automatic t_clean_clear();
    do_reset();
    for (int i = 0; i < 31; i++) col_pulse();
    tx_act_i = 1'b1; tick(513);
    tx_act_i = 1'b0; tick(1);
    col_pulse();
    check(1'b0, "R7 513-sample packet cleared count");
    for (int i = 0; i < 30; i++) col_pulse();
    check(1'b0, "R7 31 starts after clear");
    col_pulse();
    check(1'b1, "R7 32 starts after clear");
    do_reset();
    for (int i = 0; i < 31; i++) col_pulse();
    rx_act_i = 1'b1; tick(512);
    rx_act_i = 1'b0; tick(1);
    col_pulse();
    check(1'b1, "R7 512-sample packet kept count");
  endtask

  task automatic t_std_recon();
    do_reset();
    isolate();
    rx_act_i = 1'b1; tick(512);
    check(1'b1, "R3 rx 512 samples");
    tick(1);
    check(1'b0, "R3 rx 513 samples");
    rx_act_i = 1'b0; tick(1);
    do_reset();
    isolate();
    tx_act_i = 1'b1; tick(513);
    check(1'b0, "R3 tx 513 samples");
    tx_act_i = 1'b0; tick(1);
  endtask

  task automatic t_alt_recon();
    do_reset();
    alt_sel_i = 1'b1; tick(1);
    alt_sel_i = 1'b0;
    isolate();
    rx_act_i = 1'b1; tick(600);
    check(1'b1, "R4 rx ignored under alternate");
    rx_act_i = 1'b0; tick(1);
    tx_act_i = 1'b1; tick(512);
    check(1'b1, "R4 tx 512 samples");
    tick(1);
    check(1'b0, "R4 tx 513 samples");
    tx_act_i = 1'b0; tick(1);
    port_en_i = 1'b0; tick(2);
    port_en_i = 1'b1; tick(1);
    isolate();
    rx_act_i = 1'b1; tick(600);
    check(1'b1, "R5 alternate survives disable");
    rx_act_i = 1'b0; tick(1);
    do_reset();
    isolate();
    rx_act_i = 1'b1; tick(513);
    check(1'b0, "R5 default rule after reset");
    rx_act_i = 1'b0; tick(1);
  endtask

  task automatic t_recon_abort();
    do_reset();
    isolate();
    tx_act_i = 1'b1; tick(300);
    col_i = 1'b1; tick(1);
    col_i = 1'b0;
    check(1'b1, "R8 collision in attempt");
    tick(600);
    check(1'b1, "R8 rest of packet ignored");
    tx_act_i = 1'b0; tick(1);
    tx_act_i = 1'b1; tick(513);
    check(1'b0, "R8 new packet reconnects");
    tx_act_i = 1'b0; tick(1);
  endtask

  task automatic t_disable();
    do_reset();
    isolate();
    check(1'b1, "R6 isolated before disable");
    port_en_i = 1'b0; tick(1);
    check(1'b0, "R6 disable connects");
    col_i = 1'b1; tick(1100);
    check(1'b0, "R6 collision ignored while disabled");
    col_i = 1'b0; port_en_i = 1'b1; tick(1);
    check(1'b0, "R6 re-enabled connected");
    col_i = 1'b1; tick(1023);
    check(1'b0, "R6 counts restarted");
    col_i = 1'b0; tick(1);
  endtask

  task automatic t_bit_en();
    do_reset();
    bit_en_i = 1'b0;
    col_i = 1'b1; tick(1500);
    check(1'b0, "R9 no strobe no count");
    for (int i = 0; i < 1023; i++) begin
      bit_en_i = 1'b1; tick(1);
      bit_en_i = 1'b0; tick(1);
    end
    check(1'b0, "R9 1023 strobes");
    bit_en_i = 1'b1; tick(1);
    check(1'b1, "R9 1024 strobes");
    col_i = 1'b0; tick(1);
  endtask

  initial begin
    t_reset();
    t_long_col();
    t_consec();
    t_clean_clear();
    t_std_recon();
    t_alt_recon();
    t_recon_abort();
    t_disable();
    t_bit_en();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule